// File: doc/BRIEF.md
# Serial PSRAM Power-Up Reset Sequencer

This block sits on the host side of a serial pseudo-SRAM. It brings the memory out of power-up before any normal read or write traffic may use the bus. Once the supply is reported good and the host asks for bring-up, the sequencer keeps the memory bus quiet for a settling window. During that window the chip select stays deasserted, the serial clock stays low and all four data lines are driven low.

After the window it sends two single-bit SPI commands on data line 0. The first is the reset-enable byte 0x66 and the second is the reset byte 0x99. Chip select goes high for a minimum number of system cycles between the two commands. The serial clock is the system clock divided by an even factor. Data changes on the falling edge of the serial clock, so it is stable at each rising edge. After the second command the block raises a ready flag. That flag tells the host that the memory may now be used.

If the supply-good indication drops at any time, the sequencer abandons its progress and parks the bus. It then runs the whole settling window again once the supply returns.

Top module: `psram_boot_seq`

## Requirements
- R1: While no command is in flight (after reset, while waiting, in the gap between the commands and after completion), `ce_n` is 1, `sclk` is 0 and `sio` is 4'b0000; `ready` is 0 after reset.
- R2: Bring-up starts in the first clock cycle in which `supply_ok` and `start` are both 1. `ce_n` first goes low exactly QUIET_CYC cycles later, where QUIET_CYC = ceil(CLK_KHZ * QUIET_US / 1000).
- R3: Two chip-select-low windows occur. Each window holds exactly 8 rising edges of `sclk`. The bits taken from `sio[0]` at those edges, most significant bit first, form 0x66 in the first window and 0x99 in the second.
- R4: `sio[3:1]` is 0 at all times.
- R5: Between the two commands, `ce_n` stays high for at least CS_GAP_CYC system cycles.
- R6: `sclk` has period SCLK_DIV system cycles: each high phase lasts exactly SCLK_DIV/2 cycles.
- R7: `ce_n` falls at least SCLK_DIV/2 cycles before the first rising edge of a command. It rises no earlier than SCLK_DIV/2 cycles after the eighth rising edge.
- R8: `sclk` is never 1 while `ce_n` is 1.
- R9: `ready` rises exactly one cycle after `ce_n` rises at the end of the 0x99 command. It then stays 1, whatever `start` does, until reset or loss of supply.
- R10: When `supply_ok` is 0 at a clock edge, then one cycle later `ce_n` is 1, `sclk` is 0 and `ready` is 0. When the supply returns, the full QUIET_CYC wait of R2 is repeated before any command.
- R11: With `supply_ok` alone or `start` alone high, `ce_n` never falls.
- R12: `sio[0]` changes only when `sclk` is low; it holds its value through every high phase of `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Memory supply reported stable |
| start | input | 1 | Host request to begin bring-up (level) |
| ce_n | output | 1 | Memory chip select, active low |
| sclk | output | 1 | Memory serial clock |
| sio | output | 4 | Memory data lines, all driven |
| ready | output | 1 | Bring-up finished, memory usable |

## Verification
The bench builds the block with CLK_KHZ = 100000 and the real 150 µs window (QUIET_US = 150), so the settling count is 15000 cycles and the exact wait length can be measured and run more than once in the cycle budget. SCLK_DIV = 4 gives a two-cycle half period. With that setting the setup, hold and high-phase lengths of R6 and R7 are distinct, measurable counts, not a single cycle. CS_GAP_CYC = 5 makes the chip-select gap long enough that a gap shortened by one cycle is caught. A supply drop in the middle of the first command exercises the abort and the repeated full wait.

// File: rtl/psram_boot_pkg.sv
package psram_boot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_QUIET = 3'd1,
    ST_SETUP = 3'd2,
    ST_SHIFT = 3'd3,
    ST_HOLD  = 3'd4,
    ST_GAP   = 3'd5,
    ST_DONE  = 3'd6
  } boot_state_e;

  localparam int unsigned CMD_BITS = 8;
  localparam logic [CMD_BITS-1:0] CMD_RESET_ENABLE = 8'h66;
  localparam logic [CMD_BITS-1:0] CMD_RESET_DEVICE = 8'h99;

endpackage

// File: rtl/psram_boot_rstsync.sv
module psram_boot_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/psram_boot_timer.sv
module psram_boot_timer #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic             expired
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/psram_boot_shifter.sv
module psram_boot_shifter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift,
  output logic             msb
);
  logic [WIDTH-1:0] sh_q;
  logic [WIDTH-1:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = load_val;
    else if (shift) sh_d = {sh_q[WIDTH-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign msb = sh_q[WIDTH-1];
endmodule

// File: rtl/psram_boot_seq.sv
module psram_boot_seq
  import psram_boot_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 100000,
  parameter int unsigned QUIET_US   = 150,
  parameter int unsigned SCLK_DIV   = 4,
  parameter int unsigned CS_GAP_CYC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       start,
  output logic       ce_n,
  output logic       sclk,
  output logic [3:0] sio,
  output logic       ready
);
  localparam int unsigned QUIET_CYC = (CLK_KHZ * QUIET_US + 999) / 1000;
  localparam int unsigned HALF_CYC  = SCLK_DIV / 2;
  localparam int unsigned LONG_MAX  = (QUIET_CYC > CS_GAP_CYC) ? QUIET_CYC : CS_GAP_CYC;
  localparam int unsigned LONG_W    = $clog2(LONG_MAX + 1);
  localparam int unsigned HALF_W    = $clog2(HALF_CYC + 1);
  localparam int unsigned RISE_W    = $clog2(CMD_BITS + 1);

  logic rst_i_n;

  psram_boot_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  boot_state_e       state_q, state_d;
  logic              sclk_q, sclk_d;
  logic [RISE_W-1:0] rise_q, rise_d;
  logic              sel_q, sel_d;
  logic              ready_q, ready_d;

  logic              long_load;
  logic [LONG_W-1:0] long_val;
  logic              long_done;
  logic              half_load;
  logic              half_done;
  logic              sh_load;
  logic              sh_shift;
  logic              sh_msb;

  psram_boot_timer #(.WIDTH(LONG_W)) u_long_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (long_load),
    .load_val (long_val),
    .expired  (long_done)
  );

  psram_boot_timer #(.WIDTH(HALF_W)) u_half_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (half_load),
    .load_val (HALF_W'(HALF_CYC - 1)),
    .expired  (half_done)
  );

  psram_boot_shifter #(.WIDTH(CMD_BITS)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (sh_load),
    .load_val (sel_q ? CMD_RESET_DEVICE : CMD_RESET_ENABLE),
    .shift    (sh_shift),
    .msb      (sh_msb)
  );

  // next-state process
  always_comb begin
    state_d   = state_q;
    sclk_d    = sclk_q;
    rise_d    = rise_q;
    sel_d     = sel_q;
    long_load = 1'b0;
    long_val  = '0;
    half_load = 1'b0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        sclk_d = 1'b0;
        rise_d = '0;
        sel_d  = 1'b0;
        if (supply_ok && start) begin
          state_d   = ST_QUIET;
          long_load = 1'b1;
          long_val  = LONG_W'(QUIET_CYC - 1);
        end
      end
      ST_QUIET: begin
        if (long_done) begin
          state_d   = ST_SETUP;
          half_load = 1'b1;
          sh_load   = 1'b1;
          rise_d    = '0;
        end
      end
      ST_SETUP: begin
        if (half_done) begin
          state_d   = ST_SHIFT;
          sclk_d    = 1'b1;
          rise_d    = rise_q + 1'b1;
          half_load = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (half_done) begin
          half_load = 1'b1;
          if (sclk_q) begin
            sclk_d   = 1'b0;
            sh_shift = 1'b1;
            if (rise_q == RISE_W'(CMD_BITS)) state_d = ST_HOLD;
          end else begin
            sclk_d = 1'b1;
            rise_d = rise_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (half_done) begin
          if (!sel_q) begin
            state_d   = ST_GAP;
            sel_d     = 1'b1;
            long_load = 1'b1;
            long_val  = LONG_W'(CS_GAP_CYC - 1);
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_GAP: begin
        if (long_done) begin
          state_d   = ST_SETUP;
          half_load = 1'b1;
          sh_load   = 1'b1;
          rise_d    = '0;
        end
      end
      ST_DONE: begin
        sclk_d = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase

    if (!supply_ok) begin
      state_d = ST_IDLE;
      sclk_d  = 1'b0;
      rise_d  = '0;
      sel_d   = 1'b0;
    end

    ready_d = (state_q == ST_DONE) && supply_ok;
  end

  // register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      rise_q  <= '0;
      sel_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      rise_q  <= rise_d;
      sel_q   <= sel_d;
      ready_q <= ready_d;
    end
  end

  logic cmd_active;
  assign cmd_active = (state_q == ST_SETUP) || (state_q == ST_SHIFT) || (state_q == ST_HOLD);

  assign ce_n  = ~cmd_active;
  assign sclk  = sclk_q;
  assign sio   = {3'b000, cmd_active & sh_msb};
  assign ready = ready_q;
endmodule

// File: rtl/psram_boot_chk.sv
module psram_boot_chk #(
  parameter int unsigned CS_GAP_CYC = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       ce_n,
  input logic       sclk,
  input logic [3:0] sio,
  input logic       ready
);
  logic [15:0] hi_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hi_run_q <= '0;
    else if (!ce_n)              hi_run_q <= '0;
    else if (hi_run_q != 16'hFFFF) hi_run_q <= hi_run_q + 1'b1;
  end

  assert_ready_bus_parked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ce_n && !sclk && sio == 4'b0000));

  assert_upper_lines_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sio[3:1] == 3'b000);

  assert_cs_gap_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n) |-> (hi_run_q >= 16'(CS_GAP_CYC)));

  assert_no_clock_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !sclk);

  assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && supply_ok) |=> ready);

  assert_supply_loss_parks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (ce_n && !sclk && !ready));

  assert_data_hold_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sio[0]));
endmodule

bind psram_boot_seq psram_boot_chk #(.CS_GAP_CYC(CS_GAP_CYC)) i_psram_boot_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .ce_n      (ce_n),
  .sclk      (sclk),
  .sio       (sio),
  .ready     (ready)
);

// File: tb/test_psram_boot_seq.sv
module test_psram_boot_seq;
  localparam int unsigned CLK_KHZ    = 100000;
  localparam int unsigned QUIET_US   = 150;
  localparam int unsigned SCLK_DIV   = 4;
  localparam int unsigned CS_GAP_CYC = 5;
  localparam int unsigned QUIET_CYC  = (CLK_KHZ * QUIET_US + 999) / 1000;
  localparam int unsigned HALF       = SCLK_DIV / 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_ok;
  logic       start;
  logic       ce_n;
  logic       sclk;
  logic [3:0] sio;
  logic       ready;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  psram_boot_seq #(
    .CLK_KHZ(CLK_KHZ), .QUIET_US(QUIET_US),
    .SCLK_DIV(SCLK_DIV), .CS_GAP_CYC(CS_GAP_CYC)
  ) i_psram_boot_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .start(start),
    .ce_n(ce_n), .sclk(sclk), .sio(sio), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // ---------------- bus monitor (negedge sampling) ----------------
  logic       mon_clr;
  int         cyc = 0;
  logic       prev_ce = 1'b1, prev_sclk = 1'b0, prev_sio0 = 1'b0, prev_ready = 1'b0;
  int         n_win, n_fall, gap_last, hi_cnt, lo_cnt, post_cnt, high_run;
  int         setup_err, post_err, duty_err, pin_err, hold_err;
  int         ce_rise_cyc, ready_rise_cyc;
  logic [7:0] cur_byte;
  int         cur_rises;
  logic [7:0] win_byte [0:3];
  int         win_rise [0:3];

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      n_win = 0; n_fall = 0; gap_last = 0; hi_cnt = 0; lo_cnt = 0; post_cnt = 0;
      high_run = 0; setup_err = 0; post_err = 0; duty_err = 0; pin_err = 0;
      hold_err = 0; ce_rise_cyc = -100; ready_rise_cyc = -200; cur_byte = 0; cur_rises = 0;
      for (int i = 0; i < 4; i++) begin win_byte[i] = 0; win_rise[i] = 0; end
    end else begin
      if (sio[3:1] != 3'b000) pin_err++;
      if (ce_n && (sclk || sio[0])) pin_err++;
      if (sclk && prev_sclk && sio[0] != prev_sio0) hold_err++;
      if (!ce_n && prev_ce) begin
        n_fall++;
        gap_last = hi_cnt;
        lo_cnt = 0; cur_byte = 0; cur_rises = 0;
      end
      if (!ce_n && sclk && !prev_sclk) begin
        if (cur_rises == 0 && lo_cnt < HALF) setup_err++;
        cur_byte = {cur_byte[6:0], sio[0]};
        cur_rises++;
        post_cnt = 0;
      end
      if (!sclk && prev_sclk && high_run != HALF) duty_err++;
      high_run = sclk ? high_run + 1 : 0;
      if (ce_n && !prev_ce) begin
        if (post_cnt < HALF) post_err++;
        if (n_win < 4) begin win_byte[n_win] = cur_byte; win_rise[n_win] = cur_rises; end
        n_win++;
        ce_rise_cyc = cyc;
      end
      if (ready && !prev_ready) ready_rise_cyc = cyc;
      hi_cnt = ce_n ? hi_cnt + 1 : 0;
      if (!ce_n) begin lo_cnt++; post_cnt++; end
    end
    prev_ce = ce_n; prev_sclk = sclk; prev_sio0 = sio[0]; prev_ready = ready;
  end

  // watchdog
  always @(negedge clk) begin
    if (cyc > 190000) begin
      check(1'b0, "watchdog", cyc, 190000);
      report();
    end
  end

  task automatic clear_monitor();
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
  endtask

  // starts bring-up and returns number of negedges until ce_n is low
  task automatic launch_and_measure(output int waited);
    supply_ok = 1'b1;
    start     = 1'b1;
    waited    = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (ce_n && waited < QUIET_CYC + 100);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
  endtask

  task automatic check_command_pair(input string tag);
    check(n_win == 2, {tag, " R3 window count"}, n_win, 2);
    check(win_byte[0] == 8'h66, {tag, " R3 first byte"}, int'(win_byte[0]), 'h66);
    check(win_byte[1] == 8'h99, {tag, " R3 second byte"}, int'(win_byte[1]), 'h99);
    check(win_rise[0] == 8 && win_rise[1] == 8, {tag, " R3 rising edges per window"},
          win_rise[0] * 100 + win_rise[1], 808);
    check(gap_last >= CS_GAP_CYC, {tag, " R5 chip-select gap"}, gap_last, CS_GAP_CYC);
    check(duty_err == 0, {tag, " R6 sclk high phase"}, duty_err, 0);
    check(setup_err == 0 && post_err == 0, {tag, " R7 ce_n setup/hold"}, setup_err + post_err, 0);
    check(pin_err == 0, {tag, " R4 R8 R1 pin levels"}, pin_err, 0);
    check(hold_err == 0, {tag, " R12 data stable while sclk high"}, hold_err, 0);
    check(ready_rise_cyc - ce_rise_cyc == 1, {tag, " R9 ready delay"}, ready_rise_cyc - ce_rise_cyc, 1);
  endtask

  task automatic t_reset_state();
    check(ce_n == 1'b1 && sclk == 1'b0, "R1 reset ce_n/sclk", {ce_n, sclk}, 2);
    check(sio == 4'b0000, "R1 reset sio", sio, 0);
    check(ready == 1'b0, "R1 reset ready", ready, 0);
  endtask

  task automatic t_no_start();
    clear_monitor();
    supply_ok = 1'b1; start = 1'b0;
    repeat (60) @(negedge clk);
    supply_ok = 1'b0; start = 1'b1;
    repeat (60) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(n_fall == 0, "R11 no activity without both inputs", n_fall, 0);
    check(pin_err == 0 && ready == 1'b0, "R1 R11 idle pins", pin_err + ready, 0);
  endtask

  task automatic t_full_sequence();
    int waited;
    clear_monitor();
    launch_and_measure(waited);
    check(waited == QUIET_CYC + 1, "R2 quiet wait length", waited, QUIET_CYC + 1);
    wait_ready();
    repeat (3) @(negedge clk);
    check_command_pair("full");
    start = 1'b0;
    repeat (20) @(negedge clk);
    check(ready == 1'b1, "R9 ready held with start low", ready, 1);
    start = 1'b1;
    repeat (5) @(negedge clk);
    check(n_win == 2 && ready == 1'b1, "R9 no repeat after done", n_win, 2);
  endtask

  task automatic t_supply_drop();
    int waited;
    // drop while ready
    supply_ok = 1'b0;
    @(negedge clk);
    check(ready == 1'b0 && ce_n == 1'b1, "R10 ready cleared on supply loss", ready, 0);
    // restart and drop in the middle of the first command
    clear_monitor();
    launch_and_measure(waited);
    check(waited == QUIET_CYC + 1, "R10 wait after supply return", waited, QUIET_CYC + 1);
    repeat (9) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    check(ce_n == 1'b1 && sclk == 1'b0 && ready == 1'b0, "R10 abort parks bus",
          {ce_n, sclk, ready}, 4);
    repeat (10) @(negedge clk);
    // full rerun from scratch
    clear_monitor();
    launch_and_measure(waited);
    check(waited == QUIET_CYC + 1, "R10 full wait repeated", waited, QUIET_CYC + 1);
    wait_ready();
    repeat (3) @(negedge clk);
    check_command_pair("restart");
  endtask

  initial begin
    mon_clr   = 1'b1;
    rst_n     = 1'b0;
    supply_ok = 1'b0;
    start     = 1'b0;
    repeat (4) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_clr = 1'b0;
    t_reset_state();
    t_no_start();
    t_full_sequence();
    t_supply_drop();
    report();
  end
endmodule